// File: doc/BRIEF.md
# PLL Clock Control Register with Interlocks

This block is a byte-wide control register for a clock unit built around a frequency-multiplying PLL. Software writes one byte with the fields: a PLL run enable, a 2-bit multiplication code, a system clock source select and a 2-bit peripheral clock select. The block drives the PLL enable and ratio code outputs and the clock-mux select outputs from these fields.

The block enforces the rules that keep the system clock safe:
- The PLL output can be chosen as the system clock only while the PLL runs.
- The PLL output can be chosen only after the PLL has had time to lock following a change of ratio.
- Any ratio change sends the system clock back to the raw oscillator.
- A settle counter, loaded from a lock-time parameter given in clock cycles, blocks re-selection of the PLL clock until it expires.
- A stop-mode input holds the PLL off without changing the stored fields.

Top module: `pll_clkctl`

## Requirements
- R1: After reset the register reads 0x11, the ratio output is 00, and `pll_on`, `sysclk_sel` and `pll_locking` are 0, while `vcont_release` is 1.
- R2: Bits 0 and 4 of `rd_data` always read 1, whatever value was written to them.
- R3: Ratio codes 01, 10 and 11 (meaning ×2, ×3, ×4) written to bits 3:2 appear on `pll_ratio`. A write with code 00 leaves the ratio unchanged and starts no lock wait.
- R4: A write with bit 1 (PLL enable) at 0 leaves bit 5 (system clock select) at 0, even when bit 5 is written as 1.
- R5: A write that clears the PLL enable clears the system clock select at the same clock edge.
- R6: A write that changes the ratio clears the system clock select at that edge, even when the same write sets bit 5. It also raises `pll_locking` for exactly LOCK_CYCLES cycles.
- R7: While `pll_locking` is high, writes that set the system clock select are ignored. Once it has fallen, such a write takes effect.
- R8: While `stop_mode` is high, `pll_on` is 0 and `vcont_release` is 1, and the stored enable bit is kept.
- R9: Bits 7:6 are stored, read back, and drive `periph_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| stop_mode | input | 1 | Stop mode, forces the PLL off |
| rd_data | output | 8 | Register read value |
| pll_on | output | 1 | PLL run enable |
| pll_ratio | output | 2 | Multiplication code |
| sysclk_sel | output | 1 | 0 selects the oscillator, 1 selects the PLL clock |
| periph_sel | output | 2 | Peripheral clock select |
| vcont_release | output | 1 | Control-voltage output released |
| pll_locking | output | 1 | Lock wait in progress |

## Verification
Two events can land on the same edge: a ratio change and a request to select the PLL clock. The bench writes a byte that sets bit 5 and also carries a new ratio while the PLL clock is already selected. It then checks that the select drops to 0 and the lock wait starts. It also measures the lock wait cycle by cycle, and checks that a select request is refused inside the wait and accepted after it.

// File: rtl/pll_clkctl.sv
module pll_clkctl #(
  parameter int LOCK_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       stop_mode,
  output logic [7:0] rd_data,
  output logic       pll_on,
  output logic [1:0] pll_ratio,
  output logic       sysclk_sel,
  output logic [1:0] periph_sel,
  output logic       vcont_release,
  output logic       pll_locking
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(LOCK_CYCLES);

  logic          en_q, sel_q;
  logic [1:0]    ratio_q, per_q;
  logic [CW-1:0] cnt_q;

  wire [1:0] ratio_wr  = wr_data[3:2];
  wire       ratio_chg = (ratio_wr != 2'b00) && (ratio_wr != ratio_q);
  wire       settling  = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sel_q   <= 1'b0;
      ratio_q <= 2'b00;
      per_q   <= 2'b00;
      cnt_q   <= '0;
    end else begin
      if (wr_en) begin
        en_q  <= wr_data[1];
        per_q <= wr_data[7:6];
        if (ratio_chg) ratio_q <= ratio_wr;
        sel_q <= wr_data[5] & wr_data[1] & ~ratio_chg & (~settling | sel_q);
      end
      if (wr_en && ratio_chg) cnt_q <= LOAD;
      else if (settling)      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pll_on        = en_q & ~stop_mode;
  assign vcont_release = ~pll_on;
  assign pll_ratio     = ratio_q;
  assign sysclk_sel    = sel_q;
  assign periph_sel    = per_q;
  assign pll_locking   = settling;
  assign rd_data       = {per_q, sel_q, 1'b1, ratio_q, en_q, 1'b1};

  a_r2_reserved_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] && rd_data[4]);
  a_r3_zero_code_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3:2] == 2'b00) |=> $stable(pll_ratio));
  a_r4_no_sel_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[1]) |=> !sysclk_sel);
  a_r5_fall_clears_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[1]) |-> !sysclk_sel);
  a_r6_change_falls_back: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3:2] != 2'b00 && wr_data[3:2] != pll_ratio) |=> (pll_locking && !sysclk_sel));
  a_r7_hold_while_locking: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_locking && !sysclk_sel) |=> !sysclk_sel);
  a_r8_stop_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> (!pll_on && vcont_release));
endmodule

// File: tb/pll_clkctl_tb.sv
module pll_clkctl_tb;
  localparam int L = 40;
  logic clk = 0, rst_n = 0, wr_en = 0, stop_mode = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic pll_on, sysclk_sel, vcont_release, pll_locking;
  logic [1:0] pll_ratio, periph_sel;
  int total = 0, bad = 0;

  pll_clkctl #(.LOCK_CYCLES(L)) u_dut (.clk, .rst_n, .wr_en, .wr_data, .stop_mode,
    .rd_data, .pll_on, .pll_ratio, .sysclk_sel, .periph_sel, .vcont_release, .pll_locking);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_unlock();
    while (pll_locking) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rd", rd_data, 8'h11); chk("R1 ratio", pll_ratio, 0);
    chk("R1 on", pll_on, 0); chk("R1 sel", sysclk_sel, 0);
    chk("R1 lock", pll_locking, 0); chk("R1 vrel", vcont_release, 1);
  endtask

  task automatic t_sel_blocked();
    wr(8'h20);
    chk("R4 sel", sysclk_sel, 0); chk("R2 rd", rd_data, 8'h11);
  endtask

  task automatic t_lock_len();
    int n = 0;
    wr(8'h06);
    chk("R3 ratio x2", pll_ratio, 2'b01); chk("R6 lock", pll_locking, 1);
    while (pll_locking && n < 10*L) begin n++; @(negedge clk); end
    chk("R6 lock length", n, L);
  endtask

  task automatic t_lock_block();
    wr(8'h0E); chk("R3 ratio x4", pll_ratio, 2'b11);
    wr(8'h2E); chk("R7 sel refused", sysclk_sel, 0);
    wait_unlock();
    wr(8'h2E); chk("R7 sel accepted", sysclk_sel, 1);
  endtask

  task automatic t_same_cycle();
    wr(8'h2A);
    chk("R6 sel drop", sysclk_sel, 0); chk("R6 lock", pll_locking, 1);
    chk("R3 ratio x3", pll_ratio, 2'b10);
    wait_unlock();
    wr(8'h2A); chk("R7 sel again", sysclk_sel, 1);
  endtask

  task automatic t_zero_ratio();
    wr(8'h22);
    chk("R3 ratio kept", pll_ratio, 2'b10); chk("R3 no lock", pll_locking, 0);
    chk("R3 sel kept", sysclk_sel, 1);
  endtask

  task automatic t_disable();
    wr(8'h20);
    chk("R5 sel", sysclk_sel, 0); chk("R5 on", pll_on, 0);
  endtask

  task automatic t_stop();
    wr(8'h0A); chk("R8 on", pll_on, 1);
    @(negedge clk); stop_mode = 1; @(negedge clk);
    chk("R8 off", pll_on, 0); chk("R8 vrel", vcont_release, 1); chk("R8 kept", rd_data[1], 1);
    stop_mode = 0; @(negedge clk);
    chk("R8 back", pll_on, 1);
  endtask

  task automatic t_periph();
    wr(8'hCA);
    chk("R9 per", periph_sel, 2'b11); chk("R9 rd", rd_data, 8'hDB);
  endtask

  initial begin
    #1; #25 rst_n = 1;
    @(negedge clk);
    t_reset(); t_sel_blocked(); t_lock_len(); t_lock_block(); t_same_cycle();
    t_zero_ratio(); t_disable(); t_stop(); t_periph();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule